// File: doc/BRIEF.md
# Sub-word load/store alignment unit

This unit sits between a small integer core and a data memory that is organised as whole 32-bit words. For each accepted request it forms the effective address from a base register value and a signed immediate. It checks that address against the access size. It always reads one aligned word from memory. A load picks out the addressed byte, halfword or word and extends it to the register width, then writes it to the destination register port. A store merges the bytes from rs2 into the word it has just read and writes the whole word back.

The unit takes one request per cycle through a valid/ready handshake. The word read is issued in the cycle a request is accepted. The register write or the merged memory write follows in the next cycle. The memory is expected to have separate read and write addresses and to return read data one cycle after the read is issued. A read of a word that is being written in that same cycle must see the old contents. The unit forwards the newly written word itself, so back-to-back accesses to one word still see each other's effects.

Top module: `lsu_align_top`

## Requirements
- R1: In the cycle a request is accepted (req_valid and req_ready both high), the effective address is req_rs1 plus req_imm sign-extended from 12 bits. mem_raddr carries that address with bits 1:0 forced to zero.
- R2: A load of a known opcode that is aligned and names a non-zero register sets rd_we one cycle after acceptance. In that cycle rd_addr is the request's req_rd and rd_wdata is the selected data. Byte lane k of a memory word is bits 8k+7:8k (little-endian), and address bits 1:0 select the lane.
- R3: Opcode 0x0 (byte) and 0x1 (halfword) sign-extend the selected data to 32 bits. Opcode 0x4 (byte) and 0x5 (halfword) zero-extend it. Opcode 0x2 loads the full word.
- R4: Opcodes 0x8 (byte), 0x9 (halfword) and 0xA (word) are stores. One cycle after acceptance they set mem_we, with mem_waddr equal to the word address. mem_wdata is the previous word with the addressed lanes replaced by the low bytes of req_rs2 and all other lanes unchanged. A store never sets rd_we.
- R5: Word opcodes (0x2, 0xA) need address bits 1:0 equal to 0. Halfword opcodes (0x1, 0x5, 0x9) need bit 0 equal to 0. Byte opcodes accept any address. mem_re is high in the acceptance cycle exactly for known opcodes that meet this rule.
- R6: A request that breaks the alignment rule raises mis_err for one cycle, one cycle after acceptance. It causes no memory read, no memory write and no register write.
- R7: A load that names register 0 reads memory but does not set rd_we.
- R8: A request that touches the word written by the store in the cycle before it sees that store's data, for both loads and merging stores.
- R9: While rst_n is low, req_ready, mem_re, mem_we, rd_we and mis_err are low. req_ready rises one cycle after reset is released and stays high, so one request is accepted per cycle.
- R10: An accepted request with any opcode other than the eight listed causes no memory access, no register write and no mis_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 4 | Operation code: bit 3 store, bit 2 unsigned, bits 1:0 size |
| req_rs1 | input | 32 | Base register value |
| req_rs2 | input | 32 | Store data register value |
| req_imm | input | 12 | Signed address offset |
| req_rd | input | 5 | Destination register index for loads |
| mem_re | output | 1 | Word read enable |
| mem_raddr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_re |
| mem_we | output | 1 | Word write enable |
| mem_waddr | output | 32 | Word-aligned write address |
| mem_wdata | output | 32 | Full word to write |
| rd_we | output | 1 | Destination register write enable |
| rd_addr | output | 5 | Destination register index |
| rd_wdata | output | 32 | Extended load result |
| mis_err | output | 1 | Misaligned access pulse |

## Verification
The read enable and the read address depend only on the inputs, so they are checked in the same cycle, shortly after the request is driven. The register write, the merged memory write and the misalignment pulse are registered behind the acceptance edge. The bench drives each request on a falling edge and compares all of these outputs on the next falling edge. By then exactly one rising edge has passed. A behavioural model applies each request in order to its own copy of memory, and the expected outputs come from that copy. The model is compared on every cycle, including idle cycles, which must stay quiet. Sequences of dependent stores and loads to one word check the forwarding path.

// File: rtl/lsu_pkg.sv
// Package: shared operation codes and decode helpers for the load/store
// alignment unit. Code layout: bit 3 = store, bit 2 = unsigned, bits 1:0 =
// size (0 byte, 1 halfword, 2 word). Codes outside the eight listed are unknown.
package lsu_pkg;

    typedef enum logic [3:0] {
        OP_LD_B   = 4'h0,
        OP_LD_H   = 4'h1,
        OP_LD_W   = 4'h2,
        OP_LD_BU  = 4'h4,
        OP_LD_HU  = 4'h5,
        OP_ST_B   = 4'h8,
        OP_ST_H   = 4'h9,
        OP_ST_W   = 4'hA
    } lsu_op_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // True for one of the eight supported operation codes.
    function automatic logic op_known(input logic [3:0] op);
        case (op)
            OP_LD_B, OP_LD_H, OP_LD_W, OP_LD_BU, OP_LD_HU,
            OP_ST_B, OP_ST_H, OP_ST_W: op_known = 1'b1;
            default:                   op_known = 1'b0;
        endcase
    endfunction

    // True for store codes.
    function automatic logic op_store(input logic [3:0] op);
        op_store = op[3];
    endfunction

    // True for zero-extending load codes.
    function automatic logic op_unsigned(input logic [3:0] op);
        op_unsigned = op[2];
    endfunction

    // Access size field.
    function automatic logic [1:0] op_size(input logic [3:0] op);
        op_size = op[1:0];
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
// Module: effective address generation and alignment check.
// Adds the sign-extended immediate to the base, splits the sum into a
// word-aligned address and a byte lane, and flags accesses whose size does
// not fit their lane. Purely combinational. Assumes IMM_W <= AW.
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int IMM_W  = 12,
    parameter int LANE_W = 2
) (
    input  logic [AW-1:0]     base,
    input  logic [IMM_W-1:0]  imm,
    input  logic [1:0]        size,
    output logic [AW-1:0]     word_addr,
    output logic [LANE_W-1:0] lane,
    output logic              misaligned
);

    logic [AW-1:0] eff_addr;

    // Sum base and sign-extended offset.
    always_comb begin
        eff_addr = base + {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
    end

    // Split the address into word part and lane.
    always_comb begin
        word_addr = {eff_addr[AW-1:LANE_W], {LANE_W{1'b0}}};
        lane      = eff_addr[LANE_W-1:0];
    end

    // Size-dependent alignment rule.
    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = eff_addr[0];
            default: misaligned = (eff_addr[LANE_W-1:0] != '0);
        endcase
    end

endmodule

// File: rtl/lsu_load_extract.sv
// Module: load data extraction.
// Shifts the addressed lane of a little-endian word down to bit 0 and
// sign- or zero-extends a byte or halfword. Combinational. Assumes
// DATA_W = 8 * 2**LANE_W.
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [DATA_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        size,
    input  logic              uns,
    output logic [DATA_W-1:0] value
);

    localparam int SH_W = LANE_W + 3;

    logic [DATA_W-1:0] shifted;
    logic              byte_fill;
    logic              half_fill;

    // Bring the addressed lane down to bit 0.
    always_comb begin
        shifted = word >> SH_W'({lane, 3'b000});
    end

    // Extension bits for the two sub-word sizes.
    always_comb begin
        byte_fill = ~uns & shifted[7];
        half_fill = ~uns & shifted[15];
    end

    // Pick the result for the access size.
    always_comb begin
        case (size)
            SZ_BYTE: value = {{(DATA_W-8){byte_fill}},  shifted[7:0]};
            SZ_HALF: value = {{(DATA_W-16){half_fill}}, shifted[15:0]};
            default: value = shifted;
        endcase
    end

endmodule

// File: rtl/lsu_store_merge.sv
// Module: store data merge.
// Replaces the lanes of the previous word that a byte, halfword or word store
// covers with the low bytes of the store data; other lanes pass through.
// Combinational. Assumes the lane is already aligned for the size.
module lsu_store_merge
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] st_data,
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] merged
);

    localparam int NB = DATA_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam logic [LANE_W-1:0] IDX = LANE_W'(i);
        logic       hit;
        logic [7:0] src;

        // Decide whether this lane is covered and where its byte comes from.
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    hit = (lane == IDX);
                    src = st_data[7:0];
                end
                SZ_HALF: begin
                    hit = (lane[LANE_W-1:1] == IDX[LANE_W-1:1]);
                    src = st_data[(i % 2)*8 +: 8];
                end
                default: begin
                    hit = 1'b1;
                    src = st_data[i*8 +: 8];
                end
            endcase
        end

        assign merged[i*8 +: 8] = hit ? src : old_word[i*8 +: 8];
    end

endmodule

// File: rtl/lsu_align_top.sv
// Module: sub-word load/store alignment unit, top level.
// Accepts one request per cycle. In the accept cycle the aligned word is read.
// In the next cycle the load result goes to the register port, or the merged
// word goes to memory. A word written in one cycle and read in the same cycle
// is forwarded, because the memory returns its old contents in that case.
// Assumes a memory with separate read and write addresses and one-cycle read
// latency.
module lsu_align_top
    import lsu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [AW-1:0]     req_rs1,
    input  logic [DATA_W-1:0] req_rs2,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [REG_AW-1:0] req_rd,
    output logic              mem_re,
    output logic [AW-1:0]     mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_we,
    output logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_wdata,
    output logic              mis_err
);

    localparam int NB     = DATA_W / 8;
    localparam int LANE_W = $clog2(NB);

    // Accept-stage signals
    logic              rdy_q;
    logic              fire;
    logic              known;
    logic [AW-1:0]     a_word;
    logic [LANE_W-1:0] a_lane;
    logic              a_mis;
    logic              access;
    logic              fwd_hit;

    // Second-stage registers
    logic              s_vld;
    logic              s_mis;
    logic              s_store;
    logic              s_uns;
    logic [1:0]        s_size;
    logic [LANE_W-1:0] s_lane;
    logic [REG_AW-1:0] s_rd;
    logic [DATA_W-1:0] s_data;
    logic [AW-1:0]     s_addr;
    logic              s_fwd;
    logic [DATA_W-1:0] s_fwd_data;

    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] ld_value;

    // Ready rises once reset is gone and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= 1'b1;
    end

    assign req_ready = rdy_q;

    // Handshake and opcode decode.
    always_comb begin
        fire   = req_valid & rdy_q;
        known  = op_known(req_op);
        access = fire & known & ~a_mis;
    end

    lsu_addr_gen #(
        .AW     (AW),
        .IMM_W  (IMM_W),
        .LANE_W (LANE_W)
    ) u_addr (
        .base       (req_rs1),
        .imm        (req_imm),
        .size       (op_size(req_op)),
        .word_addr  (a_word),
        .lane       (a_lane),
        .misaligned (a_mis)
    );

    // Read port driven in the accept cycle.
    always_comb begin
        mem_re    = access;
        mem_raddr = a_word;
    end

    // Same-word write now means the memory's next read data is stale.
    always_comb begin
        fwd_hit = access & mem_we & (mem_waddr == a_word);
    end

    // Capture the accepted request for the second stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vld      <= 1'b0;
            s_mis      <= 1'b0;
            s_store    <= 1'b0;
            s_uns      <= 1'b0;
            s_size     <= SZ_BYTE;
            s_lane     <= '0;
            s_rd       <= '0;
            s_data     <= '0;
            s_addr     <= '0;
            s_fwd      <= 1'b0;
            s_fwd_data <= '0;
        end else begin
            s_vld      <= fire & known;
            s_mis      <= fire & known & a_mis;
            s_store    <= op_store(req_op);
            s_uns      <= op_unsigned(req_op);
            s_size     <= op_size(req_op);
            s_lane     <= a_lane;
            s_rd       <= req_rd;
            s_data     <= req_rs2;
            s_addr     <= a_word;
            s_fwd      <= fwd_hit;
            s_fwd_data <= mem_wdata;
        end
    end

    // Previous word contents: forwarded copy or memory read data.
    always_comb begin
        old_word = s_fwd ? s_fwd_data : mem_rdata;
    end

    lsu_load_extract #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_extract (
        .word  (old_word),
        .lane  (s_lane),
        .size  (s_size),
        .uns   (s_uns),
        .value (ld_value)
    );

    lsu_store_merge #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_merge (
        .old_word (old_word),
        .st_data  (s_data),
        .lane     (s_lane),
        .size     (s_size),
        .merged   (merged)
    );

    // Second-stage results to memory and register file.
    always_comb begin
        mem_we    = s_vld & ~s_mis & s_store;
        mem_waddr = s_addr;
        mem_wdata = merged;
        rd_we     = s_vld & ~s_mis & ~s_store & (s_rd != '0);
        rd_addr   = s_rd;
        rd_wdata  = ld_value;
        mis_err   = s_vld & s_mis;
    end

    // R1: read addresses are always word aligned
    assert_raddr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_raddr[LANE_W-1:0] == '0));

    // R3: a signed byte load result carries its sign bit upward
    assert_byte_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && s_size == SZ_BYTE && !s_uns) |-> (rd_wdata[DATA_W-1:8] == {(DATA_W-8){rd_wdata[7]}}));

    // R4: memory writes are aligned and never paired with a register write
    assert_store_no_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!rd_we && mem_waddr[LANE_W-1:0] == '0));

    // R6: a misalignment pulse comes with no write of any kind
    assert_mis_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mis_err |-> (!mem_we && !rd_we));

    // R7: register 0 is never written
    assert_no_x0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_addr != '0));

    // R9: ready is high from the cycle after reset release onward
    assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> req_ready);

endmodule

// File: tb/tb_lsu_align_top.sv
// Bench: a behavioural reference memory applies each request in order. Every
// cycle the DUT's outputs are compared with the model's expected results.
module tb_lsu_align_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = 4'h0;
    logic [31:0] req_rs1 = '0;
    logic [31:0] req_rs2 = '0;
    logic [11:0] req_imm = '0;
    logic [4:0]  req_rd = '0;
    logic        mem_re;
    logic [31:0] mem_raddr;
    logic [31:0] mem_rdata;
    logic        mem_we;
    logic [31:0] mem_waddr;
    logic [31:0] mem_wdata;
    logic        rd_we;
    logic [4:0]  rd_addr;
    logic [31:0] rd_wdata;
    logic        mis_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_align_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_rs1(req_rs1), .req_rs2(req_rs2), .req_imm(req_imm),
        .req_rd(req_rd), .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .rd_we(rd_we), .rd_addr(rd_addr), .rd_wdata(rd_wdata), .mis_err(mis_err)
    );

    // Bench memory: 16 words, registered read, old data on same-cycle write.
    logic [31:0] bmem [16];
    logic [31:0] ref_mem [16];
    logic [31:0] rdata_q = '0;
    assign mem_rdata = rdata_q;

    always @(posedge clk) begin
        if (mem_re) rdata_q <= bmem[mem_raddr[5:2]];
        if (mem_we) bmem[mem_waddr[5:2]] <= mem_wdata;
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Pending expectation for the request accepted at the last edge.
    bit          p_vld = 0;
    bit          p_mis, p_rdwe, p_mwe;
    logic [4:0]  p_rda;
    logic [31:0] p_rdd, p_wa, p_wd;
    string       p_tag;
    logic [31:0] last_wa = 32'hFFFF_FFFF;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare second-stage outputs with the pending expectation (or idle).
    task automatic check_stage();
        if (p_vld) begin
            chk(p_tag, "mis_err", {31'b0, mis_err}, {31'b0, p_mis});
            chk(p_tag, "rd_we",   {31'b0, rd_we},   {31'b0, p_rdwe});
            if (p_rdwe) begin
                chk(p_tag, "rd_addr",  {27'b0, rd_addr}, {27'b0, p_rda});
                chk(p_tag, "rd_wdata", rd_wdata, p_rdd);
            end
            chk(p_tag, "mem_we", {31'b0, mem_we}, {31'b0, p_mwe});
            if (p_mwe) begin
                chk(p_tag, "mem_waddr", mem_waddr, p_wa);
                chk(p_tag, "mem_wdata", mem_wdata, p_wd);
            end
        end else begin
            chk("R10", "idle outputs", {29'b0, mis_err, rd_we, mem_we}, 32'h0);
        end
    endtask

    // Model one request, check the accept-cycle read, record expectations.
    task automatic model(input logic [3:0] op, input logic [31:0] rs1, input logic [11:0] imm,
                         input logic [31:0] rs2, input logic [4:0] rd);
        logic [31:0] ea, w, v, nw;
        int off, sz, bytes;
        bit known, st, uns, ok;
        ea = rs1 + {{20{imm[11]}}, imm};
        off = int'(ea[1:0]);
        known = (op inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA});
        st = op[3]; uns = op[2]; sz = int'(op[1:0]);
        bytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        ok = known && ((off % bytes) == 0);
        chk("R5", "mem_re", {31'b0, mem_re}, {31'b0, ok});
        if (ok) chk("R1", "mem_raddr", mem_raddr, {ea[31:2], 2'b00});
        w = ref_mem[ea[5:2]];
        v = w >> (8 * off);
        if (bytes == 1) v = uns ? (v & 32'hFF) : {{24{v[7]}}, v[7:0]};
        else if (bytes == 2) v = uns ? (v & 32'hFFFF) : {{16{v[15]}}, v[15:0]};
        nw = w;
        for (int b = 0; b < bytes; b++) nw[(off+b)*8 +: 8] = rs2[b*8 +: 8];
        p_vld = known;
        p_mis = known && !ok;
        p_rdwe = ok && !st && (rd != 0);
        p_mwe = ok && st;
        p_rda = rd; p_rdd = v; p_wa = {ea[31:2], 2'b00}; p_wd = nw;
        if (!known) p_tag = "R10";
        else if (!ok) p_tag = "R6";
        else if (last_wa == p_wa) p_tag = "R8";
        else if (st) p_tag = "R4";
        else if (rd == 0) p_tag = "R7";
        else if (bytes < 4) p_tag = "R3";
        else p_tag = "R2";
        if (p_mwe) begin
            ref_mem[ea[5:2]] = nw;
            last_wa = p_wa;
        end else begin
            last_wa = 32'hFFFF_FFFF;
        end
    endtask

    task automatic req(input logic [3:0] op, input logic [31:0] rs1, input logic [11:0] imm,
                       input logic [31:0] rs2, input logic [4:0] rd);
        @(negedge clk);
        check_stage();
        req_valid = 1'b1; req_op = op; req_rs1 = rs1; req_imm = imm; req_rs2 = rs2; req_rd = rd;
        #1;
        model(op, rs1, imm, rs2, rd);
    endtask

    task automatic idle();
        @(negedge clk);
        check_stage();
        req_valid = 1'b0;
        #1;
        chk("R10", "mem_re idle", {31'b0, mem_re}, 32'h0);
        p_vld = 0;
        last_wa = 32'hFFFF_FFFF;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            bmem[i]    = 32'h0101_0101 * i ^ 32'hA55A_0000;
            ref_mem[i] = 32'h0101_0101 * i ^ 32'hA55A_0000;
        end
        repeat (3) @(negedge clk);
        // R9: quiet outputs during reset
        chk("R9", "reset outputs", {27'b0, req_ready, mem_re, mem_we, rd_we, mis_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "ready after reset", {31'b0, req_ready}, 32'h1);
        // word store then word load
        req(4'hA, 32'h0000_000C, 12'h004, 32'h1122_3344, 5'd1);
        req(4'h2, 32'h0000_0014, 12'hFFC, 32'h0, 5'd2);
        // signed / unsigned byte and halfword extraction
        req(4'hA, 32'h0000_0020, 12'h000, 32'h80FF_7F01, 5'd0);
        idle();
        req(4'h0, 32'h0000_0020, 12'h000, 32'h0, 5'd3);
        req(4'h0, 32'h0000_0020, 12'h001, 32'h0, 5'd4);
        req(4'h0, 32'h0000_0020, 12'h002, 32'h0, 5'd5);
        req(4'h4, 32'h0000_0020, 12'h003, 32'h0, 5'd6);
        req(4'h0, 32'h0000_0020, 12'h003, 32'h0, 5'd7);
        req(4'h1, 32'h0000_0030, 12'hFF2, 32'h0, 5'd8);
        req(4'h5, 32'h0000_0030, 12'hFF2, 32'h0, 5'd9);
        req(4'h1, 32'h0000_0020, 12'h000, 32'h0, 5'd10);
        // byte / halfword stores merging into prior data
        req(4'h8, 32'h0000_0008, 12'h003, 32'hDEAD_BE77, 5'd0);
        req(4'h2, 32'h0000_0008, 12'h000, 32'h0, 5'd11);
        req(4'h9, 32'h0000_0004, 12'h002, 32'hFFFF_C3D2, 5'd0);
        req(4'h8, 32'h0000_0004, 12'h000, 32'h0000_0099, 5'd0);
        req(4'h8, 32'h0000_0004, 12'h001, 32'h0000_0066, 5'd0);
        req(4'h2, 32'h0000_0004, 12'h000, 32'h0, 5'd12);
        idle();
        // misaligned accesses, then confirm memory unchanged
        req(4'h2, 32'h0000_0010, 12'h001, 32'h0, 5'd13);
        req(4'h1, 32'h0000_0010, 12'h003, 32'h0, 5'd14);
        req(4'hA, 32'h0000_0010, 12'h002, 32'hFFFF_FFFF, 5'd0);
        req(4'h9, 32'h0000_0010, 12'h001, 32'hFFFF_FFFF, 5'd0);
        req(4'h5, 32'h0000_0010, 12'h002, 32'h0, 5'd15);
        req(4'h2, 32'h0000_0010, 12'h000, 32'h0, 5'd16);
        // register 0 and unknown opcodes
        req(4'h2, 32'h0000_0010, 12'h000, 32'h0, 5'd0);
        req(4'h3, 32'h0000_0010, 12'h000, 32'h0, 5'd17);
        req(4'hF, 32'h0000_0010, 12'h000, 32'h1234_5678, 5'd18);
        req(4'hB, 32'h0000_0014, 12'h000, 32'h1234_5678, 5'd19);
        req(4'h2, 32'h0000_0014, 12'h000, 32'h0, 5'd20);
        // negative offset wrapping below base
        req(4'h9, 32'h0000_0040, 12'hFFE, 32'h0000_ABCD, 5'd0);
        req(4'h1, 32'h0000_0040, 12'hFFE, 32'h0, 5'd21);
        req(4'h2, 32'h0000_0040, 12'hFFC, 32'h0, 5'd22);
        idle();
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule